// File: doc/BRIEF.md
# Reset cause status register

This block holds a 16-bit control and status word that tells firmware why the chip last came out of reset or woke from a low-power state. Other logic sends it one-cycle strobes: power-on, supply brown-out, external pin reset, software reset instruction, watchdog expiry, trap conflict, and illegal opcode or uninitialized register use. It also gets strobes for entering idle or sleep, for leaving deep sleep, and for a watchdog clear. A two-bit input gives the current power mode. Each flag has its own set sources and its own clear sources.

Firmware reads the word after start-up to find the cause, then usually writes the flags back to zero. A power-on also sets the brown-out flag. So a real brown-out is the brown-out flag set while the power-on flag is clear, and that only works if firmware cleared both after the last power-on. The block never asserts a reset itself.

The bus is a plain register port: a write strobe with data, and a read word that always shows the stored value. It has no stream interface, so no valid/ready handshake and no back-pressure. A write takes effect at the next rising clock edge.

Top module: `rst_cause_reg`

## Requirements
- R1: After `rst_n` is released, or one cycle after an `ev_por` strobe, the word reads 0x0003 (only bits 1 and 0 set). A power-on beats every other input in the same cycle.
- R2: Bit positions are fixed: 15 trap conflict, 14 illegal opcode/uninitialized register, 13 software brown-out enable, 10 deep-sleep, 8 memory power in sleep, 7 pin reset, 6 software reset, 5 software watchdog enable, 4 watchdog time-out, 3 sleep, 2 idle, 1 brown-out, 0 power-on. Bits 12, 11 and 9 always read 0.
- R3: A brown-out strobe sets bit 1 and leaves bit 0 and every other bit unchanged.
- R4: A bus write loads each implemented bit (except bit 13, see R10) with either 0 or 1 at the next edge.
- R5: A pin reset strobe sets bit 7. It also sets bit 2 when the power mode is idle (`pmode`=01) and bit 3 when it is sleep (`pmode`=10). Run mode is `pmode`=00.
- R6: A watchdog time-out strobe sets bit 4. It also sets bit 2 in idle and bit 3 in sleep, with the same `pmode` encoding as R5.
- R7: An idle entry strobe sets bit 2 and a sleep entry strobe sets bit 3. Either one clears bit 4.
- R8: A watchdog clear strobe clears bits 3 and 2.
- R9: A deep-sleep exit strobe sets bits 10, 1 and 0 together.
- R10: Bit 13 accepts writes only while `bor_mode` is 01. With any other `bor_mode` it is cleared and reads 0.
- R11: If an event and a bus write touch the same bit in one cycle, the event wins. If one event sets a bit and another clears it, the set wins.
- R12: A trap conflict strobe sets bit 15, an illegal opcode strobe sets bit 14, and a software reset strobe sets bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low initialisation to 0x0003 |
| ev_por | input | 1 | Power-on event strobe |
| ev_bor | input | 1 | Brown-out event strobe |
| ev_pin | input | 1 | External pin reset strobe |
| ev_swrst | input | 1 | Software reset instruction strobe |
| ev_wdt | input | 1 | Watchdog time-out strobe |
| ev_trap | input | 1 | Trap conflict strobe |
| ev_illop | input | 1 | Illegal opcode / uninitialized register strobe |
| ev_sleep | input | 1 | Sleep entry strobe |
| ev_idle | input | 1 | Idle entry strobe |
| ev_dsexit | input | 1 | Deep-sleep exit strobe |
| wdt_clr | input | 1 | Watchdog clear strobe |
| pmode | input | 2 | Power mode: 00 run, 01 idle, 10 sleep |
| bor_mode | input | 2 | Brown-out mode configuration; 01 gives software control |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Current register contents |

## Verification
Any wrong internal state shows up directly in `bus_rdata` one cycle after the stimulus, because every bit is a single flop that drives the read word. A wrong priority shows up as the wrong bit value on the edge after a collision: write against event, set against clear, or power-on against everything. A mode-dependent decode error changes the idle or sleep bit only when `pmode` is non-zero, so each strobe is driven in all three modes. A bit 13 gating error may show up only after `bor_mode` leaves 01, one cycle later.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  localparam int W = 16;

  localparam int B_TRAP  = 15;
  localparam int B_ILLOP = 14;
  localparam int B_SWBOR = 13;
  localparam int B_DSLP  = 10;
  localparam int B_MEMPW = 8;
  localparam int B_PIN   = 7;
  localparam int B_SWRST = 6;
  localparam int B_SWWDT = 5;
  localparam int B_WDTO  = 4;
  localparam int B_SLEEP = 3;
  localparam int B_IDLE  = 2;
  localparam int B_BOR   = 1;
  localparam int B_POR   = 0;

  localparam logic [W-1:0] IMPL_MASK = 16'hE5FF;
  localparam logic [W-1:0] PON_VAL   = 16'h0003;

  typedef enum logic [1:0] {
    PM_RUN   = 2'b00,
    PM_IDLE  = 2'b01,
    PM_SLEEP = 2'b10
  } pmode_e;

  localparam logic [1:0] BORCFG_SW = 2'b01;
endpackage

// File: rtl/rcr_decode.sv
module rcr_decode
  import rcr_pkg::*;
(
  input  logic         ev_bor,
  input  logic         ev_pin,
  input  logic         ev_swrst,
  input  logic         ev_wdt,
  input  logic         ev_trap,
  input  logic         ev_illop,
  input  logic         ev_sleep,
  input  logic         ev_idle,
  input  logic         ev_dsexit,
  input  logic         wdt_clr,
  input  logic [1:0]   pmode,
  input  logic [1:0]   bor_mode,
  input  logic         bus_wr,
  output logic [W-1:0] set_mask,
  output logic [W-1:0] clr_mask,
  output logic [W-1:0] wr_mask
);
  logic in_idle, in_sleep, sw_bor;

  always_comb begin
    in_idle  = (pmode == PM_IDLE);
    in_sleep = (pmode == PM_SLEEP);
    sw_bor   = (bor_mode == BORCFG_SW);

    set_mask = '0;
    set_mask[B_TRAP]  = ev_trap;
    set_mask[B_ILLOP] = ev_illop;
    set_mask[B_DSLP]  = ev_dsexit;
    set_mask[B_PIN]   = ev_pin;
    set_mask[B_SWRST] = ev_swrst;
    set_mask[B_WDTO]  = ev_wdt;
    set_mask[B_SLEEP] = ev_sleep | ((ev_pin | ev_wdt) & in_sleep);
    set_mask[B_IDLE]  = ev_idle  | ((ev_pin | ev_wdt) & in_idle);
    set_mask[B_BOR]   = ev_bor | ev_dsexit;
    set_mask[B_POR]   = ev_dsexit;

    clr_mask = '0;
    clr_mask[B_SLEEP] = wdt_clr;
    clr_mask[B_IDLE]  = wdt_clr;
    clr_mask[B_WDTO]  = ev_sleep | ev_idle;
    clr_mask[B_SWBOR] = ~sw_bor;

    wr_mask = bus_wr ? IMPL_MASK : '0;
    wr_mask[B_SWBOR] = bus_wr & sw_bor;
  end
endmodule

// File: rtl/rcr_flag.sv
module rcr_flag #(
  parameter logic PON = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pon,
  input  logic set,
  input  logic clr,
  input  logic wr,
  input  logic wdata,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= PON;
    else if (pon)   q <= PON;
    else if (set)   q <= 1'b1;
    else if (clr)   q <= 1'b0;
    else if (wr)    q <= wdata;
  end
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rcr_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev_por,
  input  logic         ev_bor,
  input  logic         ev_pin,
  input  logic         ev_swrst,
  input  logic         ev_wdt,
  input  logic         ev_trap,
  input  logic         ev_illop,
  input  logic         ev_sleep,
  input  logic         ev_idle,
  input  logic         ev_dsexit,
  input  logic         wdt_clr,
  input  logic [1:0]   pmode,
  input  logic [1:0]   bor_mode,
  input  logic         bus_wr,
  input  logic [15:0]  bus_wdata,
  output logic [15:0]  bus_rdata
);
  logic [W-1:0] set_mask, clr_mask, wr_mask, flags;

  rcr_decode u_dec (
    .ev_bor    (ev_bor),
    .ev_pin    (ev_pin),
    .ev_swrst  (ev_swrst),
    .ev_wdt    (ev_wdt),
    .ev_trap   (ev_trap),
    .ev_illop  (ev_illop),
    .ev_sleep  (ev_sleep),
    .ev_idle   (ev_idle),
    .ev_dsexit (ev_dsexit),
    .wdt_clr   (wdt_clr),
    .pmode     (pmode),
    .bor_mode  (bor_mode),
    .bus_wr    (bus_wr),
    .set_mask  (set_mask),
    .clr_mask  (clr_mask),
    .wr_mask   (wr_mask)
  );

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_impl
      rcr_flag #(.PON(PON_VAL[i])) u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .pon   (ev_por),
        .set   (set_mask[i]),
        .clr   (clr_mask[i]),
        .wr    (wr_mask[i]),
        .wdata (bus_wdata[i]),
        .q     (flags[i])
      );
    end else begin : g_void
      assign flags[i] = 1'b0;
    end
  end

  assign bus_rdata = flags;
endmodule

// File: rtl/rcr_chk.sv
module rcr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ev_por,
  input logic        ev_bor,
  input logic        ev_pin,
  input logic        ev_sleep,
  input logic        ev_idle,
  input logic        ev_wdt,
  input logic        ev_dsexit,
  input logic        ev_trap,
  input logic [1:0]  bor_mode,
  input logic        bus_wr,
  input logic [15:0] bus_rdata
);
  // R1
  por_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_por |=> bus_rdata == 16'h0003);
  // R3
  bor_keeps_por_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bor && !ev_por && !ev_dsexit && !bus_wr) |=> bus_rdata[1] && bus_rdata[0] == $past(bus_rdata[0]));
  // R5
  pin_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pin && !ev_por) |=> bus_rdata[7]);
  // R7
  pwrsave_clears_wdto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_sleep || ev_idle) && !ev_wdt && !ev_por) |=> !bus_rdata[4]);
  // R9
  dsexit_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dsexit |=> bus_rdata[10] && bus_rdata[1] && bus_rdata[0]);
  // R10
  swbor_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bor_mode != 2'b01) |=> !bus_rdata[13]);
  // R12
  trap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_trap && !ev_por) |=> bus_rdata[15]);
endmodule

bind rst_cause_reg rcr_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ev_por    (ev_por),
  .ev_bor    (ev_bor),
  .ev_pin    (ev_pin),
  .ev_sleep  (ev_sleep),
  .ev_idle   (ev_idle),
  .ev_wdt    (ev_wdt),
  .ev_dsexit (ev_dsexit),
  .ev_trap   (ev_trap),
  .bor_mode  (bor_mode),
  .bus_wr    (bus_wr),
  .bus_rdata (bus_rdata)
);

// File: tb/rst_cause_reg_test.sv
module rst_cause_reg_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_por, ev_bor, ev_pin, ev_swrst, ev_wdt, ev_trap, ev_illop;
  logic ev_sleep, ev_idle, ev_dsexit, wdt_clr, bus_wr;
  logic [1:0] pmode, bor_mode;
  logic [15:0] bus_wdata, bus_rdata;

  localparam int P = 0, BO = 1, PIN = 2, SW = 3, WD = 4, TR = 5, IL = 6;
  localparam int SLE = 7, IDE = 8, DSX = 9, CW = 10;

  typedef struct { logic [15:0] exp; string tag; } item_t;
  item_t sb[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rst_cause_reg uut (
    .clk(clk), .rst_n(rst_n), .ev_por(ev_por), .ev_bor(ev_bor), .ev_pin(ev_pin),
    .ev_swrst(ev_swrst), .ev_wdt(ev_wdt), .ev_trap(ev_trap), .ev_illop(ev_illop),
    .ev_sleep(ev_sleep), .ev_idle(ev_idle), .ev_dsexit(ev_dsexit), .wdt_clr(wdt_clr),
    .pmode(pmode), .bor_mode(bor_mode), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  task automatic check(input logic [15:0] exp, input string tag);
    n_run++;
    if (bus_rdata !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, bus_rdata, exp);
    end
  endtask

  task automatic step(input logic [10:0] ev, input logic [1:0] pm, input logic [1:0] bm,
                      input logic wr, input logic [15:0] wd, input logic [15:0] exp,
                      input string tag);
    item_t it;
    @(negedge clk);
    ev_por = ev[P]; ev_bor = ev[BO]; ev_pin = ev[PIN]; ev_swrst = ev[SW];
    ev_wdt = ev[WD]; ev_trap = ev[TR]; ev_illop = ev[IL]; ev_sleep = ev[SLE];
    ev_idle = ev[IDE]; ev_dsexit = ev[DSX]; wdt_clr = ev[CW];
    pmode = pm; bor_mode = bm; bus_wr = wr; bus_wdata = wd;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    @(posedge clk);
  endtask

  // monitor: compares mid-cycle after each edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(it.exp, it.tag);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    ev_por = 0; ev_bor = 0; ev_pin = 0; ev_swrst = 0; ev_wdt = 0; ev_trap = 0;
    ev_illop = 0; ev_sleep = 0; ev_idle = 0; ev_dsexit = 0; wdt_clr = 0;
    pmode = 2'b00; bor_mode = 2'b01; bus_wr = 0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(16'h0003, "R1 reset value");

    step(11'd0, 2'b00, 2'b01, 1, 16'h0000, 16'h0000, "R4 write zeros");
    step(11'd0, 2'b00, 2'b01, 1, 16'hFFFF, 16'hE5FF, "R2 R4 R10 write ones");
    step(11'd0, 2'b00, 2'b00, 1, 16'hFFFF, 16'hC5FF, "R10 locked swbor");
    step(11'd0, 2'b00, 2'b00, 1, 16'h0000, 16'h0000, "R4 clear");
    step(11'd1 << BO, 2'b00, 2'b00, 0, 16'h0, 16'h0002, "R3 brown-out alone");
    step(11'd0, 2'b00, 2'b00, 1, 16'h0001, 16'h0001, "R4 write por only");
    step(11'd1 << BO, 2'b00, 2'b00, 0, 16'h0, 16'h0003, "R3 por kept");
    step(11'd0, 2'b00, 2'b00, 1, 16'h0000, 16'h0000, "R4 clear");
    step(11'd1 << PIN, 2'b00, 2'b00, 0, 16'h0, 16'h0080, "R5 pin run");
    step(11'd1 << PIN, 2'b01, 2'b00, 0, 16'h0, 16'h0084, "R5 pin idle");
    step(11'd0, 2'b00, 2'b00, 1, 16'h0000, 16'h0000, "R4 clear");
    step(11'd1 << PIN, 2'b10, 2'b00, 0, 16'h0, 16'h0088, "R5 pin sleep");
    step(11'd0, 2'b00, 2'b00, 1, 16'h0000, 16'h0000, "R4 clear");
    step(11'd1 << WD, 2'b00, 2'b00, 0, 16'h0, 16'h0010, "R6 wdt run");
    step(11'd1 << WD, 2'b01, 2'b00, 0, 16'h0, 16'h0014, "R6 wdt idle");
    step(11'd0, 2'b00, 2'b00, 1, 16'h0000, 16'h0000, "R4 clear");
    step(11'd1 << WD, 2'b10, 2'b00, 0, 16'h0, 16'h0018, "R6 wdt sleep");
    step(11'd1 << IDE, 2'b00, 2'b00, 0, 16'h0, 16'h000C, "R7 idle entry clears wdto");
    step(11'd1 << CW, 2'b00, 2'b00, 0, 16'h0, 16'h0000, "R8 wdt clear");
    step(11'd0, 2'b00, 2'b00, 1, 16'h0010, 16'h0010, "R4 write wdto");
    step(11'd1 << SLE, 2'b00, 2'b00, 0, 16'h0, 16'h0008, "R7 sleep entry");
    step((11'd1 << CW) | (11'd1 << IDE), 2'b00, 2'b00, 0, 16'h0, 16'h0004, "R11 set beats clear");
    step(11'd1 << DSX, 2'b00, 2'b00, 0, 16'h0, 16'h0407, "R9 deep-sleep exit");
    step(11'd1 << TR, 2'b00, 2'b00, 0, 16'h0, 16'h8407, "R12 trap");
    step(11'd1 << IL, 2'b00, 2'b00, 0, 16'h0, 16'hC407, "R12 illegal opcode");
    step(11'd1 << SW, 2'b00, 2'b00, 0, 16'h0, 16'hC447, "R12 software reset");
    step(11'd1 << PIN, 2'b00, 2'b00, 1, 16'h0000, 16'h0080, "R11 event beats write");
    step(11'd1 << P, 2'b00, 2'b01, 1, 16'hFFFF, 16'h0003, "R1 R11 power-on beats write");
    step(11'd0, 2'b00, 2'b00, 1, 16'h0000, 16'h0000, "R4 clear");
    step((11'd1 << SLE) | (11'd1 << WD), 2'b00, 2'b00, 0, 16'h0, 16'h0018, "R11 wdt set beats sleep clear");
    step(11'd0, 2'b00, 2'b00, 0, 16'h0, 16'h0018, "R4 hold without write");
    step(11'd0, 2'b00, 2'b01, 1, 16'h2000, 16'h2000, "R10 swbor writable");
    step(11'd0, 2'b00, 2'b10, 0, 16'h0, 16'h0000, "R10 swbor cleared");
    step(11'd0, 2'b00, 2'b00, 0, 16'h0, 16'h0000, "R10 idle");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule